// File: doc/BRIEF.md
# Serial Transmit Framer with Line Control

This block is the sending half of a classic byte-wide asynchronous serial port. Software programs it through a small byte-wide register port. One register sets the character format: word length, parity mode, stop-bit count and a break override. A 16-bit rate divisor, reached through an access-select bit in that register, feeds an oversampling tick generator. The block then frames each queued byte as start bit, data bits (least significant first), optional parity bit and stop bits on a single serial line. The line rests at logic 1 between characters.

Bytes wait in a buffer. In the default character mode it holds one byte. When the buffer mode is switched on it becomes a 16-entry queue, and a reset command drops the queued bytes without disturbing the character on the line. Two status flags report whether the buffer is empty and whether the whole transmitter has gone quiet. A second serial output carries the framed data without the break override, so a receiver can be fed in loopback.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the serial output is 1, both status flags are 1, the format register reads 0x00 and the divisor is 0.
- R2: Format bits [1:0] select 5, 6, 7 or 8 data bits for the codes 0, 1, 2, 3.
- R3: A character goes out as a 0 start bit, the data bits least significant first, the parity bit if enabled, then stop bits at 1. The line is 1 whenever nothing is being sent.
- R4: Parity is set by format bits 3 (enable), 4 (even select) and 5 (stick). With bit 3 at 0 there is no parity bit. Bits {5,4,3} of 001 give odd parity, 011 even parity, 101 a fixed 1 and 111 a fixed 0, always computed over the selected data bits only.
- R5: Format bit 2 at 0 gives one stop bit of 16 ticks. At 1 it gives 24 ticks for 5-bit words and 32 ticks for longer words.
- R6: A tick occurs every D clocks, where D is the 16-bit divisor, so each bit lasts exactly 16·D clocks. With D = 0 no ticks occur and a started character stalls in its start bit.
- R7: Format bit 6 forces the serial output to 0 while it is set. The loopback output carries the same frame with no break applied.
- R8: With format bit 7 at 1, offsets 0 and 1 write and read the low and high divisor bytes, and a write to offset 0 queues nothing. With bit 7 at 0, a write to offset 0 queues a byte and offset 1 holds a 4-bit enable field that reads back with the upper nibble 0. Offset 0 reads as 0x00 and offset 3 reads the format register.
- R9: Offset 5 reads buffer-empty in bit 5 and transmitter-empty in bit 6. Transmitter-empty is 1 only when the buffer and the shift stage are both empty. A byte write clears both flags from the next cycle.
- R10: In character mode the buffer holds one byte, and a write while it is occupied is dropped.
- R11: Writing offset 2 with bit 0 at 1 selects a 16-entry queue. Writes to a full queue are dropped. Any change of bit 0 empties the buffer.
- R12: Writing offset 2 with bits 0 and 2 both set empties the queue at once. The character already in the shift stage still completes.
- R13: When another byte is waiting, its start bit follows the previous character's last stop tick with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| tx_out | output | 1 | Serial output with break override |
| loop_out | output | 1 | Serial frame for loopback, no break override |
| thr_empty | output | 1 | Buffer empty flag |
| tx_empty | output | 1 | Buffer and shift stage both empty |

## Verification
A byte write lands at the write edge, so the status flags are checked in the half cycle that follows. In character mode the shift stage takes the byte one edge later, which makes the start bit appear and buffer-empty return one cycle after the write. Read data is registered and is sampled one cycle after the strobe. Break takes effect one cycle after the format write. Because each bit lasts exactly 16·D clocks from the start edge, frames are sampled at bit centres by counting 8·D and then 16·D falling edges from the first low sample, and stop lengths are measured as run lengths in clock cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // format register, most significant field first
  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       pen;
    logic       stb;
    logic [1:0] wls;
  } fmt_t;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_FCTL  = 3'd2;
  localparam logic [2:0] OFS_FMT   = 3'd3;
  localparam logic [2:0] OFS_LSTAT = 3'd5;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             div_zero;

  always_comb begin
    div_zero = (divisor == '0);
    tick     = !hold && !div_zero && (cnt >= divisor - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || hold || div_zero || tick) cnt <= '0;
    else                                 cnt <= cnt + ONE;
  end

  // R6
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && divisor > ONE) |=> (!tick || !$stable(divisor)));

endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         single,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty   = (count == '0);
    full    = single ? !empty : (count == FULL_CNT);
    wr_ok   = wr_en && !full && !flush;
    rd_ok   = rd_en && !empty;
    rd_data = mem[rptr];
  end

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= step(wptr);
      if (rd_ok) rptr <= step(rptr);
      count <= count + {{(CNT_W-1){1'b0}}, wr_ok} - {{(CNT_W-1){1'b0}}, rd_ok};
    end
  end

  // R11
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_ok && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       have_data,
  input  logic [7:0] data_in,
  input  logic [1:0] cfg_wls,
  input  logic       cfg_stb,
  input  logic       cfg_pen,
  input  logic       cfg_even,
  input  logic       cfg_stick,
  output logic       pop,
  output logic       line,
  output logic       busy
);
  localparam int TW = $clog2(2 * OVS);
  localparam logic [TW-1:0] LEN_ONE  = TW'(OVS - 1);
  localparam logic [TW-1:0] LEN_HALF = TW'(OVS + OVS / 2 - 1);
  localparam logic [TW-1:0] LEN_TWO  = TW'(2 * OVS - 1);

  tx_state_e   state;
  logic [TW-1:0] tcnt, bit_end;
  logic [7:0]  shreg;
  logic [2:0]  bidx, last_idx;
  logic [1:0]  wl_q;
  logic        stb_q, pen_q, par_q, last_tick;

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] wls,
                                  input logic stick, input logic even);
    logic [7:0] m;
    logic       x;
    m = d & (8'hFF >> (3'd3 - {1'b0, wls}));
    x = ^m;
    if (stick) return !even;
    return even ? x : !x;
  endfunction

  always_comb begin
    if (state == ST_STOP)
      bit_end = stb_q ? ((wl_q == 2'd0) ? LEN_HALF : LEN_TWO) : LEN_ONE;
    else
      bit_end = LEN_ONE;
    last_tick = tick && (tcnt == bit_end);
    last_idx  = {1'b0, wl_q} + 3'd4;
    pop       = have_data && ((state == ST_IDLE) || (state == ST_STOP && last_tick));
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      line  <= 1'b1;
      tcnt  <= '0;
      shreg <= '0;
      bidx  <= '0;
      wl_q  <= '0;
      stb_q <= 1'b0;
      pen_q <= 1'b0;
      par_q <= 1'b0;
    end else if (pop) begin
      state <= ST_START;
      line  <= 1'b0;
      tcnt  <= '0;
      shreg <= data_in;
      bidx  <= '0;
      wl_q  <= cfg_wls;
      stb_q <= cfg_stb;
      pen_q <= cfg_pen;
      par_q <= par_of(data_in, cfg_wls, cfg_stick, cfg_even);
    end else if (tick && state != ST_IDLE) begin
      if (!last_tick) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (state)
          ST_START: begin
            state <= ST_DATA;
            line  <= shreg[0];
            shreg <= shreg >> 1;
            bidx  <= '0;
          end
          ST_DATA: begin
            if (bidx == last_idx) begin
              if (pen_q) begin
                state <= ST_PAR;
                line  <= par_q;
              end else begin
                state <= ST_STOP;
                line  <= 1'b1;
              end
            end else begin
              bidx  <= bidx + 1'b1;
              line  <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
          ST_PAR: begin
            state <= ST_STOP;
            line  <= 1'b1;
          end
          default: begin
            state <= ST_IDLE;
            line  <= 1'b1;
          end
        endcase
      end
    end
  end

  // R3
  idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> line);

  // R6
  line_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && state != ST_IDLE) |=> $stable(line));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       tx_out,
  output logic       loop_out,
  output logic       thr_empty,
  output logic       tx_empty
);
  localparam int DIV_W = 16;

  fmt_t        fmt;
  logic [7:0]  div_lo, div_hi;
  logic [3:0]  ien;
  logic        fifo_on;
  logic        hold_wr, flush, tick, busy, pop, line, buf_empty, buf_full;
  logic [7:0]  buf_data;

  always_comb begin
    hold_wr = reg_wr && (reg_addr == OFS_DATA) && !fmt.dlab;
    flush   = reg_wr && (reg_addr == OFS_FCTL) &&
              ((reg_wdata[0] != fifo_on) || (reg_wdata[0] && reg_wdata[2]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt     <= '0;
      div_lo  <= '0;
      div_hi  <= '0;
      ien     <= '0;
      fifo_on <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DATA: if (fmt.dlab) div_lo <= reg_wdata;
        OFS_IEN:  if (fmt.dlab) div_hi <= reg_wdata;
                  else          ien    <= reg_wdata[3:0];
        OFS_FCTL: fifo_on <= reg_wdata[0];
        OFS_FMT:  fmt     <= fmt_t'(reg_wdata);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_DATA:  reg_rdata <= fmt.dlab ? div_lo : 8'h00;
        OFS_IEN:   reg_rdata <= fmt.dlab ? div_hi : {4'h0, ien};
        OFS_FMT:   reg_rdata <= fmt;
        OFS_LSTAT: reg_rdata <= {1'b0, tx_empty, thr_empty, 5'b0};
        default:   reg_rdata <= 8'h00;
      endcase
    end
  end

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .hold    (!busy),
    .divisor ({div_hi, div_lo}),
    .tick    (tick)
  );

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .single  (!fifo_on),
    .wr_en   (hold_wr),
    .wr_data (reg_wdata),
    .rd_en   (pop),
    .rd_data (buf_data),
    .empty   (buf_empty),
    .full    (buf_full)
  );

  uart_tx_shifter #(.OVS(OVS)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .have_data (!buf_empty),
    .data_in   (buf_data),
    .cfg_wls   (fmt.wls),
    .cfg_stb   (fmt.stb),
    .cfg_pen   (fmt.pen),
    .cfg_even  (fmt.even),
    .cfg_stick (fmt.stick),
    .pop       (pop),
    .line      (line),
    .busy      (busy)
  );

  always_comb begin
    thr_empty = buf_empty;
    tx_empty  = buf_empty && !busy;
    tx_out    = line && !fmt.brk;
    loop_out  = line;
  end

  // R9
  write_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_wr && !buf_full) |=> !thr_empty);

  // R8
  dlab_no_enqueue_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_DATA && fmt.dlab && thr_empty) |=> thr_empty);

endmodule

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire        tx_out, loop_out, thr_empty, tx_empty;

  int errors = 0;
  int checks = 0;
  int lb_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  uart_tx_framer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_out(tx_out), .loop_out(loop_out),
    .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_div(input logic [15:0] d, input logic [7:0] fmt_after);
    wr(3'd3, 8'h80);
    wr(3'd0, d[7:0]);
    wr(3'd1, d[15:8]);
    wr(3'd3, fmt_after);
  endtask

  task automatic wait_fall(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!tx_out) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (tx_empty) begin ok = 1'b1; break; end
    end
  endtask

  task automatic quiet(input int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!tx_out) ok = 1'b0;
    end
  endtask

  function automatic logic exp_par(input logic [7:0] f, input logic [7:0] d);
    logic x = 1'b0;
    for (int i = 0; i < 5 + int'(f[1:0]); i++) x ^= d[i];
    if (f[5]) return !f[4];
    return f[4] ? x : !x;
  endfunction

  // samples one frame at bit centres and compares with the expected bits
  task automatic capture(input logic [7:0] f, input logic [7:0] d, input int dv,
                         input string req);
    logic [11:0] expv = '0, actv = '0;
    int n = 0;
    bit ok;
    expv[n++] = 1'b0;
    for (int i = 0; i < 5 + int'(f[1:0]); i++) expv[n++] = d[i];
    if (f[3]) expv[n++] = exp_par(f, d);
    expv[n++] = 1'b1;
    wait_fall(ok);
    chk(ok, req, "start bit seen", ok, 1);
    repeat (8 * dv) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      actv[k] = tx_out;
      if (loop_out !== tx_out) lb_bad++;
      if (k < n - 1) repeat (16 * dv) @(negedge clk);
    end
    chk(actv == expv, req, "frame bits", int'(actv), int'(expv));
  endtask

  task automatic runs(input int n, output int r[4]);
    bit ok;
    logic lvl;
    int cnt, k;
    for (int i = 0; i < 4; i++) r[i] = 0;
    wait_fall(ok);
    lvl = 1'b0; cnt = 1; k = 0;
    for (int i = 0; i < 5000 && k < n; i++) begin
      @(negedge clk);
      if (tx_out == lvl) cnt++;
      else begin r[k] = cnt; k++; lvl = tx_out; cnt = 1; end
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(tx_out == 1'b1, "R1", "line after reset", tx_out, 1);
    chk(thr_empty && tx_empty, "R1", "flags after reset", {tx_empty, thr_empty}, 3);
    rd(3'd3, d); chk(d == 8'h00, "R1", "format reg", d, 0);
    rd(3'd5, d); chk(d == 8'h60, "R9", "status reg idle", d, 8'h60);
  endtask

  task automatic t_remap;
    logic [7:0] d;
    bit ok;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    rd(3'd0, d); chk(d == 8'h34, "R8", "divisor low", d, 8'h34);
    rd(3'd1, d); chk(d == 8'h12, "R8", "divisor high", d, 8'h12);
    chk(thr_empty && tx_empty, "R8", "no byte queued", {tx_empty, thr_empty}, 3);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'hF5);
    rd(3'd1, d); chk(d == 8'h05, "R8", "enable field", d, 8'h05);
    rd(3'd0, d); chk(d == 8'h00, "R8", "data offset read", d, 0);
    quiet(50, ok); chk(ok, "R8", "line idle", ok, 1);
    wr(3'd3, 8'h80);
    rd(3'd1, d); chk(d == 8'h12, "R8", "divisor high kept", d, 8'h12);
    rd(3'd3, d); chk(d == 8'h80, "R8", "format readback", d, 8'h80);
  endtask

  task automatic t_frames;
    logic [7:0] fl[4] = '{8'h03, 8'h00, 8'h01, 8'h02};
    logic [7:0] dl[4] = '{8'hA5, 8'h16, 8'h2B, 8'h55};
    bit ok;
    set_div(16'd2, 8'h03);
    for (int i = 0; i < 4; i++) begin
      wr(3'd3, fl[i]);
      fork
        capture(fl[i], dl[i], 2, "R2 R3");
        wr(3'd0, dl[i]);
      join
      wait_done(ok); chk(ok, "R3", "frame finished", ok, 1);
    end
  endtask

  task automatic t_status;
    logic [7:0] d;
    bit ok;
    wr(3'd3, 8'h03);
    wr(3'd0, 8'h5A);
    chk(!thr_empty && !tx_empty, "R9", "flags after write", {tx_empty, thr_empty}, 0);
    @(negedge clk);
    chk(thr_empty && !tx_empty, "R9", "byte moved to shifter", {tx_empty, thr_empty}, 1);
    rd(3'd5, d); chk(d == 8'h20, "R9", "status while sending", d, 8'h20);
    wait_done(ok);
    rd(3'd5, d); chk(d == 8'h60, "R9", "status when done", d, 8'h60);
  endtask

  task automatic t_parity;
    logic [7:0] fl[5] = '{8'h0B, 8'h1B, 8'h2B, 8'h3B, 8'h0A};
    logic [7:0] dl[5] = '{8'hA5, 8'hA5, 8'hA5, 8'hA5, 8'hB1};
    bit ok;
    for (int i = 0; i < 5; i++) begin
      wr(3'd3, fl[i]);
      fork
        capture(fl[i], dl[i], 2, "R4");
        wr(3'd0, dl[i]);
      join
      wait_done(ok);
    end
  endtask

  task automatic t_stop;
    logic [7:0] fl[4] = '{8'h04, 8'h07, 8'h00, 8'h05};
    logic [7:0] dl[4] = '{8'h0F, 8'h7F, 8'h0F, 8'h1F};
    int ones[4] = '{4, 7, 4, 5};
    int stp[4]  = '{24, 32, 16, 32};
    int r[4];
    bit ok;
    set_div(16'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      wr(3'd3, fl[i]);
      fork
        runs(4, r);
        begin wr(3'd0, dl[i]); wr(3'd0, dl[i]); end
      join
      chk(r[0] == 16 && r[1] == 16 * ones[i] && r[2] == 16, "R5", "data runs",
          r[1], 16 * ones[i]);
      chk(r[3] == stp[i], "R5 R13", "stop run before next start", r[3], stp[i]);
      wait_done(ok);
    end
  endtask

  task automatic t_rate;
    int r[4];
    bit ok;
    set_div(16'd3, 8'h03);
    fork
      runs(2, r);
      wr(3'd0, 8'h01);
    join
    chk(r[0] == 48 && r[1] == 48, "R6", "bit length 16*3", r[0] * 1000 + r[1], 48048);
    wait_done(ok);
  endtask

  task automatic t_char_mode;
    bit ok;
    set_div(16'd1, 8'h03);
    fork
      begin capture(8'h03, 8'h11, 1, "R10"); capture(8'h03, 8'h22, 1, "R10"); end
      begin
        wr(3'd0, 8'h11);
        wr(3'd0, 8'h22);
        chk(!thr_empty, "R10", "holding occupied", thr_empty, 0);
        wr(3'd0, 8'h33);
      end
    join
    quiet(400, ok); chk(ok, "R10", "dropped byte not sent", ok, 1);
  endtask

  task automatic t_fifo_depth;
    bit ok;
    wr(3'd2, 8'h01);
    fork
      begin
        capture(8'h03, 8'hC0, 1, "R11");
        for (int i = 0; i < 16; i++) capture(8'h03, 8'(i * 7 + 1), 1, "R11");
      end
      begin
        wr(3'd0, 8'hC0);
        for (int i = 0; i < 16; i++) wr(3'd0, 8'(i * 7 + 1));
        chk(!thr_empty, "R11", "queue full", thr_empty, 0);
        wr(3'd0, 8'hEE);
      end
    join
    quiet(400, ok); chk(ok, "R11", "byte past full not sent", ok, 1);
  endtask

  task automatic t_flush;
    bit ok;
    set_div(16'd0, 8'h03);
    wr(3'd0, 8'h5A);
    repeat (100) @(negedge clk);
    chk(!tx_out && !tx_empty, "R6", "stalled in start bit", tx_out, 0);
    wr(3'd0, 8'h01); wr(3'd0, 8'h02); wr(3'd0, 8'h03);
    chk(!thr_empty, "R12", "queue holds bytes", thr_empty, 0);
    wr(3'd2, 8'h05);
    chk(thr_empty && !tx_empty, "R12", "flushed, shifter busy", {tx_empty, thr_empty}, 1);
    set_div(16'd1, 8'h03);
    wait_done(ok); chk(ok, "R12", "stalled char completes", ok, 1);
    quiet(400, ok); chk(ok, "R12", "flushed bytes not sent", ok, 1);
  endtask

  task automatic t_break;
    wr(3'd3, 8'h43);
    chk(!tx_out, "R7", "break forces 0", tx_out, 0);
    chk(loop_out, "R7", "loopback unaffected", loop_out, 1);
    chk(lb_bad == 0, "R7", "loopback matched frames", lb_bad, 0);
    wr(3'd3, 8'h03);
    chk(tx_out, "R7", "break released", tx_out, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_remap;
    t_frames;
    t_status;
    t_parity;
    t_stop;
    t_rate;
    t_char_mode;
    t_fifo_depth;
    t_flush;
    t_break;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule